// File: doc/BRIEF.md
# Video RAM Host Access Port

This block sits between a host processor and the memories of a video controller. The host queues a single byte access: a read from display DRAM, a write to display DRAM, or a write to the colour RAM. Each access goes to the location held in an auto-incrementing address pointer. The data byte passes through a one-byte latch. On a write, the latch takes the host's byte. On a read, the latch catches the byte fetched from DRAM, so that it is ready ahead of the host collecting it.

A queued access does not execute at once. It waits out a fixed settling delay. It then executes in the first cycle in which the line-timing logic opens an external access window. When a colour RAM write executes, the packed 6-bit colour is expanded to 24-bit RGB and stored. The block also records the screen position where that write disturbs one displayed pixel. That position is the current beam column moved back by the output lag and wrapped onto the previous line when needed. The display pipeline uses this record later.

Top module: `vram_host_port`

## Requirements
- R1: After synchronous reset, `busy`, `ptr_q`, `latch_q` and `glitch_valid` are all zero.
- R2: `mem_addr` always equals the low 14 bits of `ptr_q`; the upper pointer bits do not reach the DRAM address.
- R3: A request sampled in cycle c can execute no earlier than cycle c+6. It executes in the first cycle at or after c+6 in which `slot_go` is high.
- R4: While `slot_go` stays low, a pending access never executes: `busy` stays high, the pointer and latch hold, and no DRAM write occurs.
- R5: An executed read loads `latch_q` with `mem_rdata` from the address given by the pointer.
- R6: An executed write with `cram_sel` low raises `mem_we` for exactly one cycle, with `mem_wdata` equal to the byte given with the request. With `cram_sel` high, no DRAM write occurs.
- R7: Each executed access adds one to the 16-bit pointer, wrapping from 0xFFFF to 0, and clears `busy`.
- R8: Only one access can be pending. A new request replaces an unexecuted one and restarts its delay, and the replaced access never executes, even if it was eligible in that same cycle.
- R9: A colour RAM write stores into entry `ptr_q[4:0]` the value {red[23:16], green[15:8], blue[7:0]}. Red uses data bits [1:0], green bits [3:2] and blue bits [5:4]; bits [7:6] are ignored. Red and green codes 0..3 become 0, 85, 170, 255. Blue codes become 0, 104, 170, 255. `cram_rdata` shows entry `cram_raddr`.
- R10: A colour RAM write sets `glitch_valid` and records `glitch_rgb` as the stored colour. It records `glitch_col` = `beam_col` − 11 and `glitch_row` = `beam_row` when `beam_col` ≥ 11. Otherwise it records `beam_col` + 331 and the previous row, where row 0 wraps to 261.
- R11: `ptr_load` loads `ptr_value` into the pointer and takes priority over the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Queue a new access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data | input | 8 | Byte to write (loaded into the latch) |
| ptr_load | input | 1 | Load the address pointer |
| ptr_value | input | 16 | New pointer value |
| cram_sel | input | 1 | Writes target the colour RAM |
| slot_go | input | 1 | External access window open this cycle |
| beam_col | input | 9 | Current write column (0..341) |
| beam_row | input | 9 | Current write row (0..261) |
| mem_addr | output | 14 | DRAM address |
| mem_we | output | 1 | DRAM write strobe |
| mem_wdata | output | 8 | DRAM write data |
| mem_rdata | input | 8 | DRAM read data for `mem_addr` |
| latch_q | output | 8 | Read-ahead / write data latch |
| ptr_q | output | 16 | Address pointer |
| busy | output | 1 | An access is pending |
| cram_raddr | input | 5 | Colour RAM read index |
| cram_rdata | output | 24 | Colour RAM entry, packed RGB |
| glitch_valid | output | 1 | A glitch position has been recorded |
| glitch_row | output | 9 | Row of the last glitch |
| glitch_col | output | 9 | Column of the last glitch |
| glitch_rgb | output | 24 | Colour written at the last glitch |

## Verification
The hardest case to bring about is R8 with a replacement that lands in the very cycle where the older access has just become eligible and a window is open. Here two paths compete: one would execute the old access and one would queue the new one. To reach it, the bench keeps `slot_go` low through the whole settling delay of a first write. In the sixth cycle it opens the window and issues a second write at the same moment. It then checks that exactly one DRAM write happens, that it carries the second byte, and that it arrives six cycles later. The other sweeps cover every colour code, every window start offset around the delay boundary, and beam columns on both sides of the lag wrap, including row 0.

// File: rtl/vhp_pkg.sv
package vhp_pkg;
   localparam int BYTE_W = 8;
   localparam int CODE_W = 6;
   localparam int CH_W   = 8;
   localparam int RGB_W  = 3 * CH_W;

   typedef logic [BYTE_W-1:0] byte_t;
   typedef logic [RGB_W-1:0]  rgb_t;

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/vhp_req_queue.sv
module vhp_req_queue #(
   parameter int MIN_DELAY = 6
) (
   input  logic clk,
   input  logic rst,
   input  logic req_valid,
   input  logic req_write,
   input  logic slot_go,
   output logic busy,
   output logic exec,
   output logic exec_write
);
   import vhp_pkg::*;

   acc_kind_e kind_q;
   logic      ready;

   always_ff @(posedge clk) begin
      if (rst)            kind_q <= ACC_IDLE;
      else if (req_valid) kind_q <= req_write ? ACC_WRITE : ACC_READ;
      else if (exec)      kind_q <= ACC_IDLE;
   end

   generate
      if (MIN_DELAY > 1) begin : g_delay
         localparam int CW = $clog2(MIN_DELAY);
         logic [CW-1:0] wait_q;
         always_ff @(posedge clk) begin
            if (rst)               wait_q <= '0;
            else if (req_valid)    wait_q <= CW'(MIN_DELAY - 1);
            else if (wait_q != '0) wait_q <= wait_q - 1'b1;
         end
         assign ready = (wait_q == '0);
      end else begin : g_nodelay
         assign ready = 1'b1;
      end
   endgenerate

   assign busy       = (kind_q != ACC_IDLE);
   assign exec       = busy && ready && slot_go && !req_valid;
   assign exec_write = (kind_q == ACC_WRITE);
endmodule

// File: rtl/vhp_color_conv.sv
module vhp_color_conv #(
   parameter int BLUE_LVL1 = 104
) (
   input  logic [vhp_pkg::CODE_W-1:0] code,
   output vhp_pkg::rgb_t              rgb
);
   import vhp_pkg::*;

   localparam int STEP = (2**CH_W - 1) / 3;

   function automatic logic [CH_W-1:0] lin_level(input logic [1:0] c);
      return CH_W'(int'(c) * STEP);
   endfunction

   function automatic logic [CH_W-1:0] blue_level(input logic [1:0] c);
      return (c == 2'd1) ? CH_W'(BLUE_LVL1) : CH_W'(int'(c) * STEP);
   endfunction

   assign rgb = {lin_level(code[1:0]), lin_level(code[3:2]), blue_level(code[5:4])};
endmodule

// File: rtl/vhp_glitch_pos.sv
module vhp_glitch_pos #(
   parameter int LINE_COLS = 342,
   parameter int LINE_ROWS = 262,
   parameter int LAG       = 11,
   localparam int COL_W    = $clog2(LINE_COLS),
   localparam int ROW_W    = $clog2(LINE_ROWS)
) (
   input  logic [COL_W-1:0] col_in,
   input  logic [ROW_W-1:0] row_in,
   output logic [COL_W-1:0] col_out,
   output logic [ROW_W-1:0] row_out
);
   logic before_line;

   assign before_line = (int'(col_in) < LAG);

   always_comb begin
      if (before_line) begin
         col_out = COL_W'(int'(col_in) + LINE_COLS - LAG);
         row_out = (row_in == '0) ? ROW_W'(LINE_ROWS - 1) : row_in - 1'b1;
      end else begin
         col_out = COL_W'(int'(col_in) - LAG);
         row_out = row_in;
      end
   end
endmodule

// File: rtl/vram_host_port.sv
module vram_host_port #(
   parameter int PTR_W      = 16,
   parameter int ADDR_W     = 14,
   parameter int CRAM_DEPTH = 32,
   parameter int MIN_DELAY  = 6,
   parameter int LINE_COLS  = 342,
   parameter int LINE_ROWS  = 262,
   parameter int OUT_LAG    = 11,
   parameter int BLUE_LVL1  = 104,
   localparam int CRAM_AW   = $clog2(CRAM_DEPTH),
   localparam int COL_W     = $clog2(LINE_COLS),
   localparam int ROW_W     = $clog2(LINE_ROWS)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [7:0]          req_data,
   input  logic                ptr_load,
   input  logic [PTR_W-1:0]    ptr_value,
   input  logic                cram_sel,
   input  logic                slot_go,
   input  logic [COL_W-1:0]    beam_col,
   input  logic [ROW_W-1:0]    beam_row,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic                mem_we,
   output logic [7:0]          mem_wdata,
   input  logic [7:0]          mem_rdata,
   output logic [7:0]          latch_q,
   output logic [PTR_W-1:0]    ptr_q,
   output logic                busy,
   input  logic [CRAM_AW-1:0]  cram_raddr,
   output logic [23:0]         cram_rdata,
   output logic                glitch_valid,
   output logic [ROW_W-1:0]    glitch_row,
   output logic [COL_W-1:0]    glitch_col,
   output logic [23:0]         glitch_rgb
);
   import vhp_pkg::*;

   generate
      if (ADDR_W > PTR_W) begin : g_bad_addr
         $error("vram_host_port: ADDR_W exceeds PTR_W");
      end
      if (CRAM_DEPTH != (2**CRAM_AW) || CRAM_AW > PTR_W) begin : g_bad_cram
         $error("vram_host_port: CRAM_DEPTH must be a power of two within the pointer");
      end
      if (MIN_DELAY < 1) begin : g_bad_delay
         $error("vram_host_port: MIN_DELAY must be at least 1");
      end
      if (OUT_LAG >= LINE_COLS || LINE_ROWS < 2) begin : g_bad_geom
         $error("vram_host_port: line geometry out of range");
      end
   endgenerate

   logic exec, exec_write;
   logic dram_wr, cram_wr, exec_read;
   rgb_t conv_rgb;
   logic [COL_W-1:0] g_col;
   logic [ROW_W-1:0] g_row;
   rgb_t cram_mem [CRAM_DEPTH];

   vhp_req_queue #(.MIN_DELAY(MIN_DELAY)) u_queue (
      .clk        (clk),
      .rst        (rst),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .slot_go    (slot_go),
      .busy       (busy),
      .exec       (exec),
      .exec_write (exec_write)
   );

   vhp_color_conv #(.BLUE_LVL1(BLUE_LVL1)) u_conv (
      .code (latch_q[CODE_W-1:0]),
      .rgb  (conv_rgb)
   );

   vhp_glitch_pos #(
      .LINE_COLS (LINE_COLS),
      .LINE_ROWS (LINE_ROWS),
      .LAG       (OUT_LAG)
   ) u_glitch (
      .col_in  (beam_col),
      .row_in  (beam_row),
      .col_out (g_col),
      .row_out (g_row)
   );

   assign exec_read = exec && !exec_write;
   assign dram_wr   = exec && exec_write && !cram_sel;
   assign cram_wr   = exec && exec_write && cram_sel;

   // pointer: explicit load wins over the post-access increment
   always_ff @(posedge clk) begin
      if (rst)           ptr_q <= '0;
      else if (ptr_load) ptr_q <= ptr_value;
      else if (exec)     ptr_q <= ptr_q + 1'b1;
   end

   // data latch: host byte on write request, DRAM byte on executed read
   always_ff @(posedge clk) begin
      if (rst)                         latch_q <= '0;
      else if (req_valid && req_write) latch_q <= req_data;
      else if (exec_read)              latch_q <= mem_rdata;
   end

   always_ff @(posedge clk) begin
      if (cram_wr) cram_mem[ptr_q[CRAM_AW-1:0]] <= conv_rgb;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         glitch_valid <= 1'b0;
         glitch_row   <= '0;
         glitch_col   <= '0;
         glitch_rgb   <= '0;
      end else if (cram_wr) begin
         glitch_valid <= 1'b1;
         glitch_row   <= g_row;
         glitch_col   <= g_col;
         glitch_rgb   <= conv_rgb;
      end
   end

   assign mem_addr   = ptr_q[ADDR_W-1:0];
   assign mem_we     = dram_wr;
   assign mem_wdata  = latch_q;
   assign cram_rdata = cram_mem[cram_raddr];
endmodule

// File: rtl/vhp_checker.sv
module vhp_checker #(
   parameter int PTR_W     = 16,
   parameter int MIN_DELAY = 6,
   parameter int LINE_COLS = 342,
   localparam int COL_W    = $clog2(LINE_COLS),
   localparam int AGE_W    = $clog2(MIN_DELAY + 2)
) (
   input logic             clk,
   input logic             rst,
   input logic             req_valid,
   input logic             ptr_load,
   input logic             exec,
   input logic             exec_write,
   input logic             busy,
   input logic [7:0]       mem_rdata,
   input logic [7:0]       latch_q,
   input logic [PTR_W-1:0] ptr_q,
   input logic             glitch_valid,
   input logic [COL_W-1:0] glitch_col
);
   logic [AGE_W-1:0] age_q;

   always_ff @(posedge clk) begin
      if (rst)                           age_q <= '0;
      else if (req_valid)                age_q <= AGE_W'(1);
      else if (int'(age_q) < MIN_DELAY)  age_q <= age_q + 1'b1;
   end

   AST_NO_EARLY_ACCESS: assert property (@(posedge clk) disable iff (rst)
      exec |-> (int'(age_q) >= MIN_DELAY)); // R3

   AST_READ_FILLS_LATCH: assert property (@(posedge clk) disable iff (rst)
      (exec && !exec_write && !req_valid) |=> (latch_q == $past(mem_rdata))); // R5

   AST_PTR_ADVANCES: assert property (@(posedge clk) disable iff (rst)
      (exec && !ptr_load) |=> (ptr_q == $past(ptr_q) + 1'b1)); // R7

   AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
      (exec && !req_valid) |=> !busy); // R7

   AST_NEW_REQ_PENDS: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> busy); // R8

   AST_GLITCH_COL_RANGE: assert property (@(posedge clk) disable iff (rst)
      glitch_valid |-> (int'(glitch_col) < LINE_COLS)); // R10
endmodule

bind vram_host_port vhp_checker #(
   .PTR_W     (PTR_W),
   .MIN_DELAY (MIN_DELAY),
   .LINE_COLS (LINE_COLS)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .req_valid    (req_valid),
   .ptr_load     (ptr_load),
   .exec         (exec),
   .exec_write   (exec_write),
   .busy         (busy),
   .mem_rdata    (mem_rdata),
   .latch_q      (latch_q),
   .ptr_q        (ptr_q),
   .glitch_valid (glitch_valid),
   .glitch_col   (glitch_col)
);

// File: tb/tb_vram_host_port.sv
`timescale 1ns/1ps
module tb_vram_host_port;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [7:0]  req_data = '0;
   logic        ptr_load = 1'b0;
   logic [15:0] ptr_value = '0;
   logic        cram_sel = 1'b0, slot_go = 1'b0;
   logic [8:0]  beam_col = '0, beam_row = '0;
   logic [13:0] mem_addr;
   logic        mem_we;
   logic [7:0]  mem_wdata, mem_rdata, latch_q;
   logic [15:0] ptr_q;
   logic        busy;
   logic [4:0]  cram_raddr = '0;
   logic [23:0] cram_rdata, glitch_rgb;
   logic        glitch_valid;
   logic [8:0]  glitch_row, glitch_col;

   int checks = 0, failures = 0;
   int wr_cnt = 0;
   logic [13:0] wr_addr;
   logic [7:0]  wr_data;
   bit done = 0;

   always #2.5 clk = ~clk;

   function automatic logic [7:0] ram_model(input logic [13:0] a);
      return a[7:0] ^ {2'b00, a[13:8]};
   endfunction
   assign mem_rdata = ram_model(mem_addr);

   vram_host_port dut (.*);

   always @(posedge clk) if (mem_we) begin
      wr_cnt++;
      wr_addr = mem_addr;
      wr_data = mem_wdata;
   end

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic load_ptr(input logic [15:0] v);
      ptr_load = 1'b1; ptr_value = v; cyc(); ptr_load = 1'b0;
   endtask

   // request in cycle 0, window open from cycle slot_from; returns negedge index where busy fell
   task automatic run_req(input logic wr, input logic [7:0] d, input int slot_from, output int lat);
      int j;
      req_valid = 1'b1; req_write = wr; req_data = d; slot_go = (slot_from == 0);
      cyc();
      req_valid = 1'b0;
      j = 1;
      while (busy && j < 60) begin
         slot_go = (j >= slot_from);
         cyc();
         j++;
      end
      slot_go = 1'b0;
      lat = j;
   endtask

   function automatic logic [23:0] exp_rgb(input logic [5:0] c);
      logic [7:0] r, g, b;
      r = 8'(int'(c[1:0]) * 85);
      g = 8'(int'(c[3:2]) * 85);
      b = (c[5:4] == 2'd1) ? 8'd104 : 8'(int'(c[5:4]) * 85);
      return {r, g, b};
   endfunction

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int lat, w0;
      repeat (3) cyc();
      rst = 1'b0;
      cyc();
      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 ptr", ptr_q, 0);
      chk("R1 latch", latch_q, 0);
      chk("R1 glitch_valid", glitch_valid, 0);

      // R3/R5/R7/R11: window start sweep around the delay boundary
      for (int k = 0; k < 11; k++) begin
         load_ptr(16'(100 + 37 * k));
         chk("R11 ptr load", ptr_q, 100 + 37 * k);
         run_req(1'b0, 8'h00, k, lat);
         chk("R3 latency", lat, ((k > 6) ? k : 6) + 1);
         chk("R5 read data", latch_q, ram_model(14'(100 + 37 * k)));
         chk("R7 increment", ptr_q, 101 + 37 * k);
         chk("R7 busy clear", busy, 0);
      end

      // R2/R6: upper pointer bits masked from DRAM address
      load_ptr(16'hC005);
      chk("R2 addr mask", mem_addr, 14'h0005);
      w0 = wr_cnt;
      run_req(1'b1, 8'h5A, 0, lat);
      chk("R6 one write", wr_cnt - w0, 1);
      chk("R6 write addr", wr_addr, 14'h0005);
      chk("R6 write data", wr_data, 8'h5A);
      chk("R7 ptr after write", ptr_q, 16'hC006);
      chk("R2 addr follows", mem_addr, 14'h0006);

      // R7 wrap
      load_ptr(16'hFFFF);
      run_req(1'b0, 8'h00, 0, lat);
      chk("R5 read at top", latch_q, ram_model(14'h3FFF));
      chk("R7 wrap", ptr_q, 16'h0000);

      // R4 no window: nothing happens
      load_ptr(16'h0200);
      w0 = wr_cnt;
      req_valid = 1'b1; req_write = 1'b1; req_data = 8'hC3; slot_go = 1'b0;
      cyc();
      req_valid = 1'b0;
      repeat (20) cyc();
      chk("R4 busy held", busy, 1);
      chk("R4 ptr held", ptr_q, 16'h0200);
      chk("R4 no write", wr_cnt - w0, 0);
      slot_go = 1'b1; cyc(); slot_go = 1'b0;
      chk("R4 runs once open", wr_cnt - w0, 1);
      chk("R6 data after hold", wr_data, 8'hC3);

      // R8 replacement in the cycle the old one became eligible
      load_ptr(16'h0300);
      w0 = wr_cnt;
      req_valid = 1'b1; req_write = 1'b1; req_data = 8'h11; slot_go = 1'b0;
      cyc();
      req_valid = 1'b0;
      repeat (5) cyc();                 // cycles 1..5
      req_valid = 1'b1; req_data = 8'h22; slot_go = 1'b1;  // cycle 6
      cyc();
      req_valid = 1'b0;
      lat = 0;
      while (busy && lat < 40) begin cyc(); lat++; end
      slot_go = 1'b0;
      chk("R8 restart delay", lat, 6);
      chk("R8 single write", wr_cnt - w0, 1);
      chk("R8 new data", wr_data, 8'h22);
      chk("R8 addr", wr_addr, 14'h0300);

      // R9/R10/R6: colour sweep over all 64 codes
      cram_sel = 1'b1;
      beam_col = 9'd100; beam_row = 9'd40;
      w0 = wr_cnt;
      for (int c = 0; c < 64; c++) begin
         logic [4:0] ent;
         ent = 5'(c ^ 5);
         load_ptr({8'hA5, 3'b000, ent});
         run_req(1'b1, {2'(c * 3), 6'(c)}, 0, lat);
         cram_raddr = ent;
         #1;
         chk("R9 cram entry", cram_rdata, exp_rgb(6'(c)));
         chk("R10 glitch rgb", glitch_rgb, exp_rgb(6'(c)));
      end
      chk("R6 no DRAM write on colour", wr_cnt - w0, 0);
      chk("R10 valid", glitch_valid, 1);

      // R10 glitch position sweep
      for (int r = 0; r < 3; r++) begin
         for (int i = 0; i < 8; i++) begin
            int col, row, ec, er;
            col = (i == 7) ? 341 : ((i == 6) ? 200 : i * 2 + ((i > 4) ? 2 : 0));
            row = (r == 0) ? 0 : ((r == 1) ? 7 : 261);
            beam_col = 9'(col); beam_row = 9'(row);
            load_ptr(16'd3);
            run_req(1'b1, 8'h3F, 0, lat);
            ec = (col < 11) ? col + 331 : col - 11;
            er = (col < 11) ? ((row == 0) ? 261 : row - 1) : row;
            chk("R10 glitch col", glitch_col, ec);
            chk("R10 glitch row", glitch_row, er);
         end
      end
      cram_sel = 1'b0;

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule